// File: doc/BRIEF.md
# Nine-Bit Instruction Execute Datapath

This block is the execute half of a single-cycle processor whose instructions are nine bits wide. It holds four 8-bit general registers, decodes one instruction per clock, computes the result, and commits it to the destination register on the next rising edge. Fetch, program-counter sequencing and branch-target lookup sit outside the block. The block drives a small data-memory port, and it returns a zero flag that the sequencer uses to make branch decisions.

Instructions enter on a valid/ready stream. An instruction is accepted on a clock edge where `instr_valid` and `instr_ready` are both high. `instr_ready` depends only on the instruction now presented and on `mem_ready`. It goes low only while a load or store is presented and memory is not ready, so memory back-pressure holds the instruction in place. The memory port is a request stream. `mem_valid` is raised for a presented load or store. The memory answers combinationally in the same cycle: `mem_ready` high means the request completes on that edge, and for a load `mem_rdata` must then hold the addressed byte.

Top module: `nbx_exec`

## Requirements
- R1: Field layout. Bit 8 is the form: 0 selects register form, 1 selects immediate form. Bits 7:5 hold the opcode and bits 4:3 the destination register. In register form, bits 2:1 name the source register and bit 0 is the function bit. In immediate form, bits 2:0 are an unsigned immediate from 0 to 7.
- R2: In register form with function bit 0, opcodes 000, 001, 010, 011 and 100 write to the destination the AND, the sum mod 256, the difference (dest minus source) mod 256, the OR, and the XOR of the destination and source registers.
- R3: In register form with function bit 0, opcode 101 writes the low 8 bits of the product. Opcode 110 writes the unsigned quotient (dest divided by source), or 0xFF when the source is zero.
- R4: In register form with function bit 0, opcode 111 writes the smaller of the two unsigned register values to the destination.
- R5: In register form with function bit 1, opcode 101 clears the destination. Opcode 010 writes no register and loads `zero_flag` on the edge with 1 if dest equals source, else 0. Every other opcode with function bit 1 changes no state. `zero_flag` changes only on an accepted compare.
- R6: In immediate form, opcodes 000, 001, 110 and 111 write to the destination the AND with the immediate, the sum mod 256, the logical right shift by the immediate, and the logical left shift (low 8 bits). Opcodes 010 and 011 change no state.
- R7: Immediate opcode 100 is a load. It raises `mem_valid` with `mem_write` low and `mem_addr` set to the low 5 bits of the register named in bits 2:1. When accepted, it writes `mem_rdata` to the destination register.
- R8: Immediate opcode 101 is a store. It raises `mem_valid` and `mem_write`, with `mem_addr` set to the low 5 bits of the register named in bits 4:3 and `mem_wdata` set to the register named in bits 2:1. It changes no register.
- R9: `mem_valid` is high only with `instr_valid` and a load or store. `instr_ready` is low exactly when a load or store is presented and `mem_ready` is low. An instruction that is not valid, or not accepted, changes no state.
- R10: While `rst_n` is low, all four registers and `zero_flag` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Instruction can be taken this cycle |
| instr | input | 9 | Instruction word |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_write | output | 1 | 1 for store, 0 for load |
| mem_addr | output | 5 | Data-memory byte address |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Load data, valid with mem_ready |
| zero_flag | output | 1 | Registered result of the last compare |

## Verification
Two functions can land in the same cycle: a memory access and a register write to the very register that supplied its address. This happens with a load whose destination is also its address register, and with a store whose two fields name one register. The bench provokes both cases, and it also holds `mem_ready` low for several cycles under a pending access while random valid gaps run around it. A behavioural model then checks every cycle that the address, data and ready values come from the registers as they were before the edge, and that a stalled access commits nothing.

// File: rtl/nbx_pkg.sv
package nbx_pkg;
  localparam int INSTR_W  = 9;
  localparam int OPC_W    = 3;
  localparam int RIDX_W   = 2;
  localparam int IMM_W    = 3;

  typedef enum logic [3:0] {
    ALU_AND,
    ALU_ADD,
    ALU_SUB,
    ALU_OR,
    ALU_XOR,
    ALU_MUL,
    ALU_DIV,
    ALU_MIN,
    ALU_SHR,
    ALU_SHL
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG,
    OPB_IMM,
    OPB_ZERO
  } opb_src_e;

  typedef struct packed {
    alu_op_e           op;
    opb_src_e          b_src;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [IMM_W-1:0]  imm;
    logic              wr;
    logic              ld;
    logic              st;
    logic              cmp;
  } dec_t;
endpackage

// File: rtl/nbx_decode.sv
module nbx_decode
  import nbx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic             form_imm;
  logic [OPC_W-1:0] opc;
  logic             fbit;

  assign form_imm = instr[8];
  assign opc      = instr[7:5];
  assign fbit     = instr[0];

  always_comb begin
    dec       = '0;
    dec.op    = ALU_AND;
    dec.b_src = OPB_REG;
    dec.rd    = instr[4:3];
    dec.rs    = instr[2:1];
    dec.imm   = instr[2:0];
    if (!form_imm) begin
      if (!fbit) begin
        dec.wr = 1'b1;
        unique case (opc)
          3'b000:  dec.op = ALU_AND;
          3'b001:  dec.op = ALU_ADD;
          3'b010:  dec.op = ALU_SUB;
          3'b011:  dec.op = ALU_OR;
          3'b100:  dec.op = ALU_XOR;
          3'b101:  dec.op = ALU_MUL;
          3'b110:  dec.op = ALU_DIV;
          default: dec.op = ALU_MIN;
        endcase
      end else begin
        unique case (opc)
          3'b101: begin
            dec.op    = ALU_MUL;
            dec.b_src = OPB_ZERO;
            dec.wr    = 1'b1;
          end
          3'b010: begin
            dec.op  = ALU_SUB;
            dec.cmp = 1'b1;
          end
          default: ;
        endcase
      end
    end else begin
      dec.b_src = OPB_IMM;
      unique case (opc)
        3'b000: begin dec.op = ALU_AND; dec.wr = 1'b1; end
        3'b001: begin dec.op = ALU_ADD; dec.wr = 1'b1; end
        3'b110: begin dec.op = ALU_SHR; dec.wr = 1'b1; end
        3'b111: begin dec.op = ALU_SHL; dec.wr = 1'b1; end
        3'b100: begin dec.ld = 1'b1;   dec.wr = 1'b1; end
        3'b101: dec.st = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nbx_regfile.sv
module nbx_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        q <= wr_data;
      end
    end
    assign view[g] = q;
  end

  assign ra_data = view[ra_idx];
  assign rb_data = view[rb_idx];
endmodule

// File: rtl/nbx_alu.sv
module nbx_alu
  import nbx_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  localparam int SH_W = $clog2(W);

  logic [2*W-1:0] prod;
  logic [SH_W-1:0] shamt;

  assign prod  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign shamt = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_MUL: y = prod[W-1:0];
      ALU_DIV: y = (b == '0) ? {W{1'b1}} : a / b;
      ALU_MIN: y = (a < b) ? a : b;
      ALU_SHR: y = a >> shamt;
      ALU_SHL: y = a << shamt;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/nbx_exec.sv
module nbx_exec
  import nbx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [8:0]         instr,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_write,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               zero_flag
);
  localparam int NUM_REGS = 1 << RIDX_W;

  dec_t              dec;
  logic [DATA_W-1:0] ra_data;
  logic [DATA_W-1:0] rb_data;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;
  logic              alu_zero;
  logic              mem_op;
  logic              accept;
  logic [DATA_W-1:0] wb_data;
  logic              flag_q;

  nbx_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  nbx_regfile #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (dec.rd),
    .rb_idx  (dec.rs),
    .ra_data (ra_data),
    .rb_data (rb_data),
    .wr_en   (accept && dec.wr),
    .wr_idx  (dec.rd),
    .wr_data (wb_data)
  );

  always_comb begin
    unique case (dec.b_src)
      OPB_IMM:  opnd_b = DATA_W'(dec.imm);
      OPB_ZERO: opnd_b = '0;
      default:  opnd_b = rb_data;
    endcase
  end

  nbx_alu #(.W(DATA_W)) u_alu (
    .op   (dec.op),
    .a    (ra_data),
    .b    (opnd_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign mem_op      = dec.ld || dec.st;
  assign instr_ready = !mem_op || mem_ready;
  assign accept      = instr_valid && instr_ready;

  assign mem_valid = instr_valid && mem_op;
  assign mem_write = dec.st;
  assign mem_addr  = dec.st ? ra_data[MADDR_W-1:0] : rb_data[MADDR_W-1:0];
  assign mem_wdata = rb_data;

  assign wb_data = dec.ld ? mem_rdata : alu_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (accept && dec.cmp) begin
      flag_q <= alu_zero;
    end
  end

  assign zero_flag = flag_q;
endmodule

// File: rtl/nbx_exec_chk.sv
module nbx_exec_chk #(
  parameter int DATA_W  = 8,
  parameter int MADDR_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic               instr_ready,
  input logic [8:0]         instr,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic               mem_write,
  input logic [MADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               zero_flag
);
  logic acc_cmp;
  assign acc_cmp = instr_valid && instr_ready && !instr[8] &&
                   (instr[7:5] == 3'b010) && instr[0];

  assert_req_needs_instr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> instr_valid);

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !instr_ready);

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_cmp |=> $stable(zero_flag));

  assert_store_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && instr[8] && (instr[7:5] == 3'b101)) |-> mem_write);

  assert_load_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && instr[8] && (instr[7:5] == 3'b100)) |-> !mem_write);

  assert_store_alias_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && (instr[4:3] == instr[2:1])) |->
      (mem_addr == mem_wdata[MADDR_W-1:0]));
endmodule

bind nbx_exec nbx_exec_chk #(
  .DATA_W  (DATA_W),
  .MADDR_W (MADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .instr       (instr),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_write   (mem_write),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .zero_flag   (zero_flag)
);

// File: tb/tb_nbx_exec.sv
module tb_nbx_exec;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic       instr_ready;
  logic [8:0] instr = '0;
  logic       mem_valid;
  logic       mem_ready = 1'b1;
  logic       mem_write;
  logic [4:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic       zero_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] bmem [32];
  int mreg [4];
  int mflag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = bmem[mem_addr];

  nbx_exec dut (
    .clk (clk), .rst_n (rst_n),
    .instr_valid (instr_valid), .instr_ready (instr_ready), .instr (instr),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_write (mem_write),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .zero_flag (zero_flag)
  );

  function automatic logic [8:0] rform(int op, int rd, int rs, int f);
    return {1'b0, 3'(op), 2'(rd), 2'(rs), 1'(f)};
  endfunction

  function automatic logic [8:0] iform(int op, int rd, int imm);
    return {1'b1, 3'(op), 2'(rd), 3'(imm)};
  endfunction

  function automatic string tag_of(logic [8:0] ins);
    int op = int'(ins[7:5]);
    if (!ins[8]) begin
      if (ins[0]) return "R5";
      if (op <= 4) return "R2";
      if (op == 7) return "R4";
      return "R3";
    end
    if (op == 4) return "R7";
    if (op == 5) return "R8";
    return "R6";
  endfunction

  task automatic step(input logic [8:0] ins, input logic v, input logic rdy, input string tag);
    int op, rd, rs, f, imm, a, b, res;
    bit is_mem, e_ready, e_mv, e_mw, acc, ok;
    int e_addr, e_wd;
    @(negedge clk);
    instr = ins; instr_valid = v; mem_ready = rdy;
    #1;
    op = int'(ins[7:5]); rd = int'(ins[4:3]); rs = int'(ins[2:1]);
    f = int'(ins[0]); imm = int'(ins[2:0]);
    a = mreg[rd]; b = mreg[rs];
    is_mem  = ins[8] && (op == 4 || op == 5);
    e_ready = !is_mem || rdy;
    e_mv    = v && is_mem;
    e_mw    = (op == 5);
    e_addr  = (op == 5) ? (a & 31) : (b & 31);
    e_wd    = b;
    ok = (instr_ready == e_ready) && (mem_valid == e_mv) && (zero_flag == mflag[0]);
    if (e_mv) begin
      ok = ok && (mem_write == e_mw) && (int'(mem_addr) == e_addr);
      if (e_mw) ok = ok && (int'(mem_wdata) == e_wd);
    end
    acc = v && e_ready;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ins=%b got rdy=%0b mv=%0b mw=%0b addr=%0d wd=%0d zf=%0b exp rdy=%0b mv=%0b mw=%0b addr=%0d wd=%0d zf=%0d",
               acc ? tag : "R9", ins, instr_ready, mem_valid, mem_write, mem_addr, mem_wdata,
               zero_flag, e_ready, e_mv, e_mw, e_addr, e_wd, mflag);
    end
    @(posedge clk);
    if (acc) begin
      if (!ins[8]) begin
        if (!f) begin
          case (op)
            0: res = a & b;
            1: res = (a + b) & 255;
            2: res = (a - b) & 255;
            3: res = a | b;
            4: res = a ^ b;
            5: res = (a * b) & 255;
            6: res = (b == 0) ? 255 : a / b;
            default: res = (a < b) ? a : b;
          endcase
          mreg[rd] = res;
        end else if (op == 5) begin
          mreg[rd] = 0;
        end else if (op == 2) begin
          mflag = (a == b) ? 1 : 0;
        end
      end else begin
        case (op)
          0: mreg[rd] = a & imm;
          1: mreg[rd] = (a + imm) & 255;
          6: mreg[rd] = a >> imm;
          7: mreg[rd] = (a << imm) & 255;
          4: mreg[rd] = int'(bmem[b & 31]);
          5: bmem[a & 31] = 8'(b);
          default: ;
        endcase
      end
    end
  endtask

  task automatic probe(int r, string tag);
    step(iform(5, 0, r << 1), 1'b1, 1'b1, tag);
  endtask

  task automatic reload();
    step(iform(0, 0, 0), 1'b1, 1'b1, "R6");
    step(iform(1, 0, 3), 1'b1, 1'b1, "R6");
    step(iform(4, 1, 0), 1'b1, 1'b1, "R7");
    step(iform(4, 2, 2), 1'b1, 1'b1, "R7");
    step(iform(4, 3, 4), 1'b1, 1'b1, "R7");
    step(iform(4, 0, 6), 1'b1, 1'b1, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) bmem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 4; i++) mreg[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (zero_flag !== 1'b0) begin
      errors++;
      $display("FAIL R10 zero_flag in reset got=%0b exp=0", zero_flag);
    end
    rst_n = 1'b1;
    // R10: every register reads zero after reset
    for (int r = 0; r < 4; r++) probe(r, "R10");

    reload();
    // R1: store with distinct fields shows which bits select which register
    step(iform(5, 2, 3 << 1), 1'b1, 1'b1, "R1");
    step(iform(5, 3, 1 << 1), 1'b1, 1'b1, "R1");

    // register-form sweep over all opcodes and register pairs
    for (int op = 0; op < 8; op++) begin
      for (int rd = 0; rd < 4; rd++) begin
        for (int rs = 0; rs < 4; rs++) begin
          step(rform(op, rd, rs, 0), 1'b1, 1'b1, tag_of(rform(op, rd, rs, 0)));
          probe(rd, tag_of(rform(op, rd, rs, 0)));
        end
        reload();
      end
    end

    // R3: divide by zero yields 0xFF; R5: clear
    step(rform(5, 2, 0, 1), 1'b1, 1'b1, "R5");
    probe(2, "R5");
    step(rform(6, 1, 2, 0), 1'b1, 1'b1, "R3");
    probe(1, "R3");
    reload();
    // R5: compare equal, hold across other ops, compare unequal
    step(rform(2, 1, 1, 1), 1'b1, 1'b1, "R5");
    step(rform(1, 0, 2, 0), 1'b1, 1'b1, "R5");
    step(rform(2, 1, 3, 1), 1'b1, 1'b1, "R5");
    step(rform(2, 2, 2, 1), 1'b1, 1'b1, "R5");
    for (int op = 0; op < 8; op++) begin
      if (op != 2 && op != 5) begin
        step(rform(op, 1, 2, 1), 1'b1, 1'b1, "R5");
        probe(1, "R5");
      end
    end
    // R6: shifts and the opcodes with no effect
    step(iform(7, 1, 7), 1'b1, 1'b1, "R6");
    probe(1, "R6");
    step(iform(6, 3, 5), 1'b1, 1'b1, "R6");
    probe(3, "R6");
    step(iform(2, 0, 7), 1'b1, 1'b1, "R6");
    step(iform(3, 2, 7), 1'b1, 1'b1, "R6");
    probe(0, "R6");
    probe(2, "R6");
    // R9: stalled store and load, and invalid cycles
    reload();
    step(iform(5, 1, 2 << 1), 1'b1, 1'b0, "R9");
    step(iform(5, 1, 2 << 1), 1'b1, 1'b0, "R9");
    step(iform(5, 1, 2 << 1), 1'b1, 1'b1, "R8");
    step(iform(4, 2, 2), 1'b1, 1'b0, "R9");
    step(iform(4, 2, 2), 1'b1, 1'b1, "R7");
    step(iform(1, 3, 7), 1'b0, 1'b1, "R9");
    step(rform(2, 0, 1, 1), 1'b0, 1'b0, "R9");
    probe(3, "R9");
    probe(2, "R7");
    // R8: store whose two fields name one register
    step(iform(5, 2, 2 << 1), 1'b1, 1'b1, "R8");

    // random stream with gaps and back-pressure
    for (int n = 0; n < 600; n++) begin
      logic [8:0] ins;
      ins = 9'($urandom);
      step(ins, ($urandom % 4) != 0, ($urandom % 3) != 0, tag_of(ins));
      if (n % 50 == 49) reload();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule